// File: doc/BRIEF.md
# Single-Channel Cycle-Steal DMA Engine

This block is one DMA channel. Software programs four registers through a simple word-wide register port: a source address, a destination address, a status word that holds the remaining byte count, and a control word. A transfer moves bytes one at a time. Each byte is a read from the source address followed by a write to the destination address, both on a valid/ready memory master port.

A transfer begins in one of two ways. Software can write the control word with the start bit set. Alternatively, a peripheral request line can be used when request enable is set. The request line first passes through an external select stage, which supplies its own enable input. In cycle-steal mode each request moves exactly one byte, so a peripheral FIFO is serviced at its own pace. Otherwise a single trigger moves the whole block.

When the count reaches zero, a sticky done flag is set and, if enabled, an interrupt is raised. The flag blocks any restart until software writes one to it. An optional auto-disable bit drops request enable at the end of the block, so the channel stops by itself.

Top module: `cs_dma`

## Requirements
- R1: After reset every register reads zero, `memReq` is low and `irq` is low.
- R2: Writing the control register (address 3) with bit 16 set starts a whole-block transfer when the count is nonzero and done is clear. Bit 16 always reads back as 0.
- R3: Each byte is a read at the source address, then a write of that byte to the destination address. While `memReq` is high and `memReady` is low, the request, address and direction stay unchanged.
- R4: When source increment (control bit 22) is set, the source address advances by 1 after each byte. Destination increment (control bit 19) does the same for the destination. When either bit is clear, that address stays fixed.
- R5: The count sits in status bits [CW-1:0] (status is address 2). It drops by one for each byte written. When it reaches zero, done (status bit 24) is set.
- R6: Done is sticky. A status write with bit 24 set clears it and leaves the count unchanged. A status write with bit 24 clear loads the count.
- R7: A start or a request is ignored while done is set, and also while the count is zero. In either case no memory access happens.
- R8: A peripheral request acts only when control bit 30 is set and `reqGateEn` is high. With cycle-steal (control bit 29) set, each request cycle seen while the channel is idle moves one byte. With bit 29 clear, a request moves the whole block. A request that arrives while the channel is busy is dropped.
- R9: If a software start and a peripheral request arrive in the same idle cycle, the start takes precedence and the whole block is moved, even in cycle-steal mode.
- R10: With auto-disable (control bit 23) set, control bit 30 is cleared when the block completes.
- R11: `irq` is high exactly while done is set and control bit 31 is set.
- R12: Status bit 25 reads 1 while a transfer is in flight. While it is 1, writes to the count and to both address registers are ignored.
- R13: The size fields (control bits 18:17 and 21:20) are stored and read back. Every unit is one byte whatever their value; 01 is the 8-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register select: 0 source, 1 destination, 2 status/count, 3 control |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Read data of the selected register (combinational) |
| periphReq | input | 1 | Peripheral request line |
| reqGateEn | input | 1 | Enable from the request-select stage |
| memReq | output | 1 | Memory access valid |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Memory address |
| memWdata | output | 8 | Write byte |
| memRdata | input | 8 | Read byte, valid when memReady is high on a read |
| memReady | input | 1 | Memory accepts or completes the access |
| irq | output | 1 | Completion interrupt |

## Verification
A software start and a peripheral request can land in the same idle cycle. The bench provokes this by asserting `periphReq` on the same clock edge that writes the control word with the start bit set, while cycle-steal and request enable are both on. The result is judged by counting destination writes: the full block count must appear rather than a single byte. A second collision is a count write that arrives while a stalled transfer is in flight. That case is judged by the final count being zero and the number of bytes moved matching the original count.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;
  // control word bit positions
  localparam int START_BIT   = 16;
  localparam int DSIZE_LSB   = 17;
  localparam int DINC_BIT    = 19;
  localparam int SSIZE_LSB   = 20;
  localparam int SINC_BIT    = 22;
  localparam int AUTOCLR_BIT = 23;
  localparam int STEAL_BIT   = 29;
  localparam int REQEN_BIT   = 30;
  localparam int INTEN_BIT   = 31;
  // status word bit positions
  localparam int DONE_BIT    = 24;
  localparam int BUSY_BIT    = 25;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } engState_t;

  typedef struct packed {
    logic wrPhase;     // destination side of a unit is on the port
    logic capture;     // read data is valid this cycle
    logic unitDone;    // destination write accepted
    logic blockEnd;    // last unit of the block accepted
  } dmaStrobe_t;
endpackage

// File: rtl/cs_dma_ctrl.sv
module cs_dma_ctrl
  import cs_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       reqLine,
  input  logic       reqEn,
  input  logic       stealMode,
  input  logic       doneFlag,
  input  logic       countZero,
  input  logic       countOne,
  input  logic       memReady,
  output dmaStrobe_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       busy
);
  engState_t state, stateNext;
  logic blockMode, blockModeNext;
  logic triggerOk, reqHit;

  assign triggerOk = !doneFlag && !countZero;
  assign reqHit    = reqLine && reqEn;

  always_comb begin
    stateNext     = state;
    blockModeNext = blockMode;
    strb          = '0;
    memReq        = 1'b0;
    memWe         = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (triggerOk && (startPulse || reqHit)) begin
          stateNext     = ST_READ;
          blockModeNext = startPulse || !stealMode;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memReady) begin
          strb.capture = 1'b1;
          stateNext    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.wrPhase = 1'b1;
        if (memReady) begin
          strb.unitDone = 1'b1;
          if (countOne) begin
            strb.blockEnd = 1'b1;
            stateNext     = ST_IDLE;
          end else if (blockMode) begin
            stateNext = ST_READ;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      blockMode <= 1'b0;
    end else begin
      state     <= stateNext;
      blockMode <= blockModeNext;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/cs_dma_datapath.sv
module cs_dma_datapath
  import cs_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [1:0]    cfgAddr,
  input  logic [31:0]   cfgWrData,
  output logic [31:0]   cfgRdData,
  input  dmaStrobe_t    strb,
  input  logic          busy,
  input  logic [7:0]    memRdata,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  output logic          startPulse,
  output logic          reqEn,
  output logic          stealMode,
  output logic          doneFlag,
  output logic          countZero,
  output logic          countOne,
  output logic [CW-1:0] countVal,
  output logic          irq
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] ADR_ONE = AW'(1);

  logic [AW-1:0] srcReg, dstReg;
  logic [CW-1:0] countReg;
  logic [31:0]   ctrlReg, ctrlNext;
  logic          doneReg;
  logic [7:0]    dataReg;
  logic          wrSrc, wrDst, wrStat, wrCtrl;

  assign wrSrc  = cfgWrEn && (cfgAddr == REG_SRC);
  assign wrDst  = cfgWrEn && (cfgAddr == REG_DST);
  assign wrStat = cfgWrEn && (cfgAddr == REG_STAT);
  assign wrCtrl = cfgWrEn && (cfgAddr == REG_CTRL);
  assign startPulse = wrCtrl && cfgWrData[START_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg <= '0;
      dstReg <= '0;
    end else begin
      if (strb.unitDone) begin
        if (ctrlReg[SINC_BIT]) srcReg <= srcReg + ADR_ONE;
        if (ctrlReg[DINC_BIT]) dstReg <= dstReg + ADR_ONE;
      end else if (!busy) begin
        if (wrSrc) srcReg <= cfgWrData[AW-1:0];
        if (wrDst) dstReg <= cfgWrData[AW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
    end else if (strb.unitDone) begin
      countReg <= countReg - CNT_ONE;
    end else if (wrStat && !cfgWrData[DONE_BIT] && !busy) begin
      countReg <= cfgWrData[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneReg <= 1'b0;
    end else if (strb.blockEnd) begin
      doneReg <= 1'b1;
    end else if (wrStat && cfgWrData[DONE_BIT]) begin
      doneReg <= 1'b0;
    end
  end

  always_comb begin
    ctrlNext = ctrlReg;
    if (strb.blockEnd && ctrlReg[AUTOCLR_BIT]) ctrlNext[REQEN_BIT] = 1'b0;
    if (wrCtrl) begin
      ctrlNext = cfgWrData;
      ctrlNext[START_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else       ctrlReg <= ctrlNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             dataReg <= '0;
    else if (strb.capture) dataReg <= memRdata;
  end

  always_comb begin
    cfgRdData = '0;
    unique case (cfgAddr)
      REG_SRC:  cfgRdData[AW-1:0] = srcReg;
      REG_DST:  cfgRdData[AW-1:0] = dstReg;
      REG_STAT: begin
        cfgRdData[CW-1:0]  = countReg;
        cfgRdData[DONE_BIT] = doneReg;
        cfgRdData[BUSY_BIT] = busy;
      end
      default:  cfgRdData = ctrlReg;
    endcase
  end

  assign memAddr   = strb.wrPhase ? dstReg : srcReg;
  assign memWdata  = dataReg;
  assign reqEn     = ctrlReg[REQEN_BIT];
  assign stealMode = ctrlReg[STEAL_BIT];
  assign doneFlag  = doneReg;
  assign countZero = (countReg == '0);
  assign countOne  = (countReg == CNT_ONE);
  assign countVal  = countReg;
  assign irq       = doneReg && ctrlReg[INTEN_BIT];
endmodule

// File: rtl/cs_dma.sv
module cs_dma
  import cs_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [1:0]    cfgAddr,
  input  logic [31:0]   cfgWrData,
  output logic [31:0]   cfgRdData,
  input  logic          periphReq,
  input  logic          reqGateEn,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  input  logic [7:0]    memRdata,
  input  logic          memReady,
  output logic          irq
);
  dmaStrobe_t    strb;
  logic          busy, startPulse, reqEn, stealMode;
  logic          doneFlag, countZero, countOne, reqLine;
  logic [CW-1:0] countVal;

  assign reqLine = periphReq && reqGateEn;

  cs_dma_ctrl u_ctrl (
    .clk, .rstN, .startPulse, .reqLine, .reqEn, .stealMode, .doneFlag,
    .countZero, .countOne, .memReady, .strb, .memReq, .memWe, .busy
  );

  cs_dma_datapath #(.AW(AW), .CW(CW)) u_dp (
    .clk, .rstN, .cfgWrEn, .cfgAddr, .cfgWrData, .cfgRdData, .strb, .busy,
    .memRdata, .memAddr, .memWdata, .startPulse, .reqEn, .stealMode,
    .doneFlag, .countZero, .countOne, .countVal, .irq
  );
endmodule

// File: rtl/cs_dma_checker.sv
module cs_dma_checker #(
  parameter int AW = 32,
  parameter int CW = 20
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          memReady,
  input logic          irq,
  input logic          doneFlag,
  input logic          busy,
  input logic [CW-1:0] countVal,
  input logic          statWrite,
  input logic          clrBit
);
  // R3: an access waiting for ready holds still
  a_r3_hold_access: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe));

  // R5: each accepted write lowers the count by one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memReady |=> countVal == $past(countVal) - CW'(1));

  // R6: done stays set until a write-one-to-clear
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !(statWrite && clrBit) |=> doneFlag);

  // R7: an idle channel with done set stays idle
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    !busy && doneFlag |=> !busy);

  // R11: interrupt only with done set
  a_r11_irq_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> doneFlag);

  // R12: count write during a transfer does not land
  a_r12_busy_count_locked: assert property (@(posedge clk) disable iff (!rstN)
    busy && statWrite && !clrBit && !(memReq && memWe && memReady)
      |=> $stable(countVal));
endmodule

bind cs_dma cs_dma_checker #(.AW(AW), .CW(CW)) chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memReady(memReady), .irq(irq), .doneFlag(doneFlag), .busy(busy),
  .countVal(countVal), .statWrite(cfgWrEn && (cfgAddr == 2'd2)),
  .clrBit(cfgWrData[24])
);

// File: tb/cs_dma_test.sv
`timescale 1ns/100ps
module cs_dma_test;
  localparam int AW = 32;
  localparam int CW = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = 2'd0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic periphReq = 1'b0;
  logic reqGateEn = 1'b1;
  logic memReq, memWe, memReady, irq;
  logic [AW-1:0] memAddr;
  logic [7:0] memWdata, memRdata;
  logic stallEn = 1'b0;
  logic readyTog = 1'b0;
  logic [7:0] dstMem [256];
  int wrCount = 0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cs_dma #(.AW(AW), .CW(CW)) uut (
    .clk, .rstN, .cfgWrEn, .cfgAddr, .cfgWrData, .cfgRdData, .periphReq,
    .reqGateEn, .memReq, .memWe, .memAddr, .memWdata, .memRdata, .memReady, .irq
  );

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a * 8'd3 + 8'h11;
  endfunction

  assign memRdata = pat(memAddr[7:0]);
  assign memReady = !stallEn || readyTog;

  always @(posedge clk) begin
    readyTog <= ~readyTog;
    cycles   <= cycles + 1;
    if (memReq && memWe && memReady) begin
      dstMem[memAddr[7:0]] <= memWdata;
      wrCount <= wrCount + 1;
    end
  end

  // control word pieces
  localparam logic [31:0] C_START = 32'h1 << 16;
  localparam logic [31:0] C_SIZE8 = (32'h1 << 17) | (32'h1 << 20);
  localparam logic [31:0] C_DINC  = 32'h1 << 19;
  localparam logic [31:0] C_SINC  = 32'h1 << 22;
  localparam logic [31:0] C_AUTO  = 32'h1 << 23;
  localparam logic [31:0] C_STEAL = 32'h1 << 29;
  localparam logic [31:0] C_REQEN = 32'h1 << 30;
  localparam logic [31:0] C_INTEN = 32'h1 << 31;
  localparam logic [31:0] S_DONE  = 32'h1 << 24;

  // {src, dst, cnt, 3'b0, stall, useReq, steal, dstInc, srcInc}
  localparam logic [31:0] VECS [6] = '{
    {8'h10, 8'h80, 8'd4, 8'b000_0_0_0_1_1},
    {8'h20, 8'h90, 8'd5, 8'b000_1_0_0_0_1},
    {8'h30, 8'hA0, 8'd3, 8'b000_0_1_1_1_1},
    {8'h40, 8'hB0, 8'd6, 8'b000_1_1_0_1_1},
    {8'h50, 8'hC0, 8'd1, 8'b000_0_0_0_1_0},
    {8'h60, 8'hD0, 8'd2, 8'b000_1_1_1_0_0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdData;
  endtask

  task automatic pulseReq();
    @(negedge clk);
    periphReq = 1'b1;
    @(negedge clk);
    periphReq = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      regRead(2'd2, s);
      if (!s[25]) break;
    end
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic runVec(input logic [31:0] v);
    logic [7:0] src, dst, cnt;
    logic [31:0] ctl, s;
    int w0, bad;
    src = v[31:24]; dst = v[23:16]; cnt = v[15:8];
    stallEn = v[4];
    ctl = C_SIZE8 | (v[0] ? C_SINC : 0) | (v[1] ? C_DINC : 0)
        | (v[2] ? C_STEAL : 0) | (v[3] ? C_REQEN : 0);
    regWrite(2'd2, S_DONE);
    regWrite(2'd0, {24'h0, src});
    regWrite(2'd1, {24'h0, dst});
    regWrite(2'd2, {24'h0, cnt});
    regWrite(2'd3, ctl);
    w0 = wrCount;
    if (v[3] && v[2]) begin
      for (int i = 0; i < int'(cnt); i++) begin
        pulseReq();
        waitIdle();
        check(wrCount - w0 == i + 1, "R8 one byte per request",
              32'(wrCount - w0), 32'(i + 1));
      end
    end else if (v[3]) begin
      pulseReq();
      waitIdle();
    end else begin
      regWrite(2'd3, ctl | C_START);
      waitIdle();
    end
    regRead(2'd2, s);
    check(s[CW-1:0] == 0 && s[24], "R5 count zero and done set", s, S_DONE);
    check(wrCount - w0 == int'(cnt), "R3 byte count written",
          32'(wrCount - w0), 32'(cnt));
    bad = 0;
    if (v[1]) begin
      for (int i = 0; i < int'(cnt); i++)
        if (dstMem[8'(dst + i)] !== pat(8'(src + (v[0] ? i : 0)))) bad++;
    end else begin
      if (dstMem[dst] !== pat(8'(src + (v[0] ? int'(cnt) - 1 : 0)))) bad++;
    end
    check(bad == 0, "R4 data at destination", 32'(bad), 0);
    stallEn = 1'b0;
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    int w0;
    idleCycles(3);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), r);
      check(r == 0, "R1 register reset value", r, 0);
    end
    check(!memReq && !irq, "R1 outputs idle", {memReq, irq}, 0);
    rstN = 1'b1;
    idleCycles(2);

    for (int v = 0; v < 6; v++) runVec(VECS[v]);

    // R7 restart blocked by done
    regWrite(2'd2, 32'd3);
    w0 = wrCount;
    regWrite(2'd3, C_SIZE8 | C_START);
    idleCycles(10);
    check(wrCount == w0, "R7 start ignored while done", 32'(wrCount - w0), 0);
    // R11 interrupt gating
    check(!irq, "R11 irq low without enable", irq, 0);
    regWrite(2'd3, C_SIZE8 | C_INTEN);
    @(negedge clk);
    check(irq, "R11 irq with done and enable", irq, 1);
    // R6 write-one-to-clear keeps count
    regWrite(2'd2, S_DONE);
    regRead(2'd2, r);
    check(!r[24] && r[CW-1:0] == 3, "R6 done cleared, count kept", r, 3);
    check(!irq, "R11 irq drops with done", irq, 0);

    // R7 count zero blocks start
    regWrite(2'd2, 32'd0);
    w0 = wrCount;
    regWrite(2'd3, C_SIZE8 | C_START);
    idleCycles(10);
    check(wrCount == w0, "R7 start ignored at zero count", 32'(wrCount - w0), 0);

    // R12 busy lockout of count and address writes
    stallEn = 1'b1;
    regWrite(2'd0, 32'h10);
    regWrite(2'd1, 32'hE0);
    regWrite(2'd2, 32'd6);
    w0 = wrCount;
    regWrite(2'd3, C_SIZE8 | C_SINC | C_DINC | C_START);
    regRead(2'd2, r);
    check(r[25], "R12 busy while in flight", r[25], 1);
    regWrite(2'd2, 32'd50);
    regWrite(2'd1, 32'h00);
    waitIdle();
    regRead(2'd2, r);
    check(r[CW-1:0] == 0 && wrCount - w0 == 6, "R12 count write ignored while busy",
          32'(wrCount - w0), 6);
    regRead(2'd1, r);
    check(r == 32'hE6, "R12 address write ignored while busy", r, 32'hE6);
    stallEn = 1'b0;

    // R8 gate and enable
    regWrite(2'd2, S_DONE);
    regWrite(2'd2, 32'd2);
    regWrite(2'd3, C_SIZE8 | C_STEAL | C_REQEN);
    reqGateEn = 1'b0;
    w0 = wrCount;
    pulseReq();
    idleCycles(6);
    check(wrCount == w0, "R8 request blocked by gate", 32'(wrCount - w0), 0);
    reqGateEn = 1'b1;
    regWrite(2'd3, C_SIZE8 | C_STEAL);
    pulseReq();
    idleCycles(6);
    check(wrCount == w0, "R8 request ignored without enable", 32'(wrCount - w0), 0);

    // R9 simultaneous start and request in steal mode
    regWrite(2'd2, 32'd4);
    regWrite(2'd3, C_SIZE8 | C_STEAL | C_REQEN | C_SINC | C_DINC);
    w0 = wrCount;
    @(negedge clk);
    cfgAddr = 2'd3;
    cfgWrData = C_SIZE8 | C_STEAL | C_REQEN | C_SINC | C_DINC | C_START;
    cfgWrEn = 1'b1; periphReq = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; periphReq = 1'b0;
    waitIdle();
    check(wrCount - w0 == 4, "R9 start wins, whole block", 32'(wrCount - w0), 4);
    regRead(2'd3, r);
    check(!r[16], "R2 start bit reads zero", r[16], 0);
    check(r[18:17] == 2'b01 && r[21:20] == 2'b01, "R13 size fields read back",
          {r[21:20], r[18:17]}, 4'b0101);

    // R10 auto-disable at block end
    regWrite(2'd2, S_DONE);
    regWrite(2'd2, 32'd3);
    regWrite(2'd3, C_SIZE8 | C_REQEN | C_AUTO);
    w0 = wrCount;
    pulseReq();
    waitIdle();
    regRead(2'd3, r);
    check(!r[30] && r[23] && wrCount - w0 == 3, "R10 request enable cleared",
          r, C_SIZE8 | C_AUTO);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule